// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block is a real-time calendar core. A slow tick, one pulse per period of a 32.768 kHz reference and synchronised to the system clock, feeds a programmable divider. The divider produces one tick per second. That tick advances the seconds, minutes and hours counters and a day, month and year calendar that knows about leap years.

Two alarm words, one for time of day and one for date, are compared against the counters on every second tick. The results, together with a once-per-second event, are recorded as sticky flags in a shared status register. Software reaches all registers through a simple single-cycle register bus:

- Writes take effect on the clock edge where the write strobe is high.
- Reads are combinational from the address.

A single interrupt line combines every flag with its enable bit.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the status, divider, time and both alarm registers read 0, the date register reads year 2000, month 1, day 1, and irq is low.
- R2: The divider register at 0x0C holds a count N in bits 15:0 and a trim value in bits 31:16. A second tick happens on every (N+1)-th slow-tick pulse, and N = 0 behaves as 32767. The trim bits read back as written and have no effect on timing.
- R3: Register offsets are status 0x08, divider 0x0C, time 0x10, date 0x14, alarm time 0x18 and alarm date 0x1C. The time layout is hours 16:12, minutes 11:6 and seconds 5:0. The date layout is year 20:9, month 8:5 and day 4:0. Any other offset reads 0, and a write to it changes nothing.
- R4: Writing the time or date register loads the counters on that edge and restarts the divider. The next second tick then comes a full N+1 pulses after the write.
- R5: On a second tick, seconds wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the day. This assumes in-range values are loaded.
- R6: The day wraps to 1 after the last day of its month and carries into the month. Month 12 wraps to 1 and carries into the year. February has 29 days when the year is divisible by 4 and either not divisible by 100 or divisible by 400; otherwise it has 28.
- R7: Status bit 1 sets on every second tick.
- R8: Status bit 0 sets on a second tick whose new time equals the alarm time word. Status bit 4 sets when, in addition, the new date equals the alarm date word. The enable bits do not gate the setting of these flags.
- R9: Writing 1 to a flag bit (0, 1 or 4) clears it, and writing 0 leaves it unchanged. An event in the same cycle wins over the clear. Bits 2, 3 and 5 are plain read-write enables, and the remaining status bits read 0.
- R10: irq is high exactly while some flag is set together with its enable: bit 0 with bit 2, bit 1 with bit 3, or bit 4 with bit 5. It stays high until software clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | One-cycle pulse per slow reference period |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the calendar across several boundaries:

- The year end.
- A 30-day month end.
- February in a leap year, in a century year and in a 400-year year.

A wrong leap rule shows up as a wrong date read back on 29 February or 1 March.

Restarting the divider on a time write is checked by pulse counting. A design that kept the old divider count would tick early after the write.

The flag tests cover the following:

- Write-0 preservation and write-1 clearing.
- A time match on the wrong date, which must set bit 0 but not bit 4.
- The zero-divider default, which must take a full 32768 pulses.

A reference model compares every register and irq on every clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int RegW = 32;

  localparam int OffStatus    = 8'h08;
  localparam int OffDivider   = 8'h0C;
  localparam int OffTime      = 8'h10;
  localparam int OffDate      = 8'h14;
  localparam int OffAlarmTime = 8'h18;
  localparam int OffAlarmDate = 8'h1C;

  localparam int BitAlarmFlag = 0;
  localparam int BitHzFlag    = 1;
  localparam int BitAlarmEn   = 2;
  localparam int BitHzEn      = 3;
  localparam int BitPairFlag  = 4;
  localparam int BitPairEn    = 5;

  localparam logic [RegW-1:0] TimeMask = 32'h0001_FFFF;
  localparam logic [RegW-1:0] DateMask = 32'h001F_FFFF;

  typedef struct packed {
    logic loadTime;
    logic loadDate;
  } calStrobeT;
endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int DivW       = 16,
  parameter int YearW      = 12,
  parameter int ResetYear  = 2000,
  parameter int DefaultDiv = 32767
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  calStrobeT       strobe,
  input  logic [RegW-1:0] wrData,
  input  logic [DivW-1:0] divCount,
  input  logic [RegW-1:0] alarmTime,
  input  logic [RegW-1:0] alarmDate,
  output logic            secTick,
  output logic            timeHit,
  output logic            pairHit,
  output logic [RegW-1:0] timeWord,
  output logic [RegW-1:0] dateWord
);
  localparam int DatePad = RegW - 9 - YearW;
  localparam int TimePad = RegW - 17;

  logic [DivW-1:0]  divCnt;
  logic [DivW-1:0]  divLimit;
  logic [5:0]       secR, minR;
  logic [4:0]       hourR, dayR;
  logic [3:0]       monR;
  logic [YearW-1:0] yearR;

  logic [5:0]       secN, minN;
  logic [4:0]       hourN, dayN;
  logic [3:0]       monN;
  logic [YearW-1:0] yearN;
  logic [4:0]       monthLen;
  logic             isLeap;
  logic             anyLoad;
  logic [RegW-1:0]  timeNext, dateNext;
  logic             unusedBits;

  assign unusedBits = ^wrData[RegW-1:9+YearW];
  assign anyLoad    = strobe.loadTime | strobe.loadDate;
  assign divLimit   = (divCount == '0) ? DivW'(DefaultDiv) : divCount;
  assign secTick    = tick && (divCnt >= divLimit) && !anyLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (anyLoad) divCnt <= '0;
    else if (tick) divCnt <= (divCnt >= divLimit) ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    int yearI;
    yearI  = int'(yearR);
    isLeap = ((yearI % 4) == 0) && (((yearI % 100) != 0) || ((yearI % 400) == 0));
    case (monR)
      4'd2:                      monthLen = isLeap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   monthLen = 5'd30;
      default:                   monthLen = 5'd31;
    endcase
  end

  always_comb begin
    secN  = secR;
    minN  = minR;
    hourN = hourR;
    dayN  = dayR;
    monN  = monR;
    yearN = yearR;
    if (secR == 6'd59) begin
      secN = '0;
      if (minR == 6'd59) begin
        minN = '0;
        if (hourR == 5'd23) begin
          hourN = '0;
          if (dayR >= monthLen) begin
            dayN = 5'd1;
            if (monR >= 4'd12) begin
              monN  = 4'd1;
              yearN = yearR + 1'b1;
            end else begin
              monN = monR + 1'b1;
            end
          end else begin
            dayN = dayR + 1'b1;
          end
        end else begin
          hourN = hourR + 1'b1;
        end
      end else begin
        minN = minR + 1'b1;
      end
    end else begin
      secN = secR + 1'b1;
    end
  end

  assign timeNext = {{TimePad{1'b0}}, hourN, minN, secN};
  assign dateNext = {{DatePad{1'b0}}, yearN, monN, dayN};
  assign timeWord = {{TimePad{1'b0}}, hourR, minR, secR};
  assign dateWord = {{DatePad{1'b0}}, yearR, monR, dayR};
  assign timeHit  = secTick && (timeNext == alarmTime);
  assign pairHit  = timeHit && (dateNext == alarmDate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR  <= '0;
      minR  <= '0;
      hourR <= '0;
      dayR  <= 5'd1;
      monR  <= 4'd1;
      yearR <= YearW'(ResetYear);
    end else begin
      if (strobe.loadTime) begin
        secR  <= wrData[5:0];
        minR  <= wrData[11:6];
        hourR <= wrData[16:12];
      end
      if (strobe.loadDate) begin
        dayR  <= wrData[4:0];
        monR  <= wrData[8:5];
        yearR <= wrData[9 +: YearW];
      end
      if (secTick) begin
        secR  <= secN;
        minR  <= minN;
        hourR <= hourN;
        dayR  <= dayN;
        monR  <= monN;
        yearR <= yearN;
      end
    end
  end

  // R5: counters stay inside their ranges
  a_r5_time_ranges: assert property (@(posedge clk) disable iff (!rstN)
    (secR < 6'd60) && (minR < 6'd60) && (hourR < 5'd24));

  // R4: a load restarts the divider, so no tick can follow right after it
  a_r4_no_tick_after_load: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> !secTick);

  // R5: every second tick moves the seconds field
  a_r5_tick_moves_seconds: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> (secR != $past(secR)));
endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DivW  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [RegW-1:0]  wrData,
  input  logic             secTick,
  input  logic             timeHit,
  input  logic             pairHit,
  input  logic [RegW-1:0]  timeWord,
  input  logic [RegW-1:0]  dateWord,
  output calStrobeT        strobe,
  output logic [DivW-1:0]  divCount,
  output logic [RegW-1:0]  alarmTime,
  output logic [RegW-1:0]  alarmDate,
  output logic [RegW-1:0]  rdData,
  output logic             irq
);
  logic selStatus, selDiv, selTime, selDate, selAlT, selAlD;
  logic wrStatus;
  logic [RegW-1:0] divTrimR;
  logic alarmFlag, hzFlag, pairFlag, alarmEn, hzEn, pairEn;
  logic [RegW-1:0] statusWord;

  assign selStatus = (addr == AddrW'(OffStatus));
  assign selDiv    = (addr == AddrW'(OffDivider));
  assign selTime   = (addr == AddrW'(OffTime));
  assign selDate   = (addr == AddrW'(OffDate));
  assign selAlT    = (addr == AddrW'(OffAlarmTime));
  assign selAlD    = (addr == AddrW'(OffAlarmDate));
  assign wrStatus  = wrEn && selStatus;

  assign strobe.loadTime = wrEn && selTime;
  assign strobe.loadDate = wrEn && selDate;
  assign divCount        = divTrimR[DivW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divTrimR  <= '0;
      alarmTime <= '0;
      alarmDate <= '0;
    end else if (wrEn) begin
      if (selDiv) divTrimR  <= wrData;
      if (selAlT) alarmTime <= wrData & TimeMask;
      if (selAlD) alarmDate <= wrData & DateMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      hzFlag    <= 1'b0;
      pairFlag  <= 1'b0;
      alarmEn   <= 1'b0;
      hzEn      <= 1'b0;
      pairEn    <= 1'b0;
    end else begin
      alarmFlag <= timeHit | (alarmFlag & ~(wrStatus & wrData[BitAlarmFlag]));
      hzFlag    <= secTick | (hzFlag & ~(wrStatus & wrData[BitHzFlag]));
      pairFlag  <= pairHit | (pairFlag & ~(wrStatus & wrData[BitPairFlag]));
      if (wrStatus) begin
        alarmEn <= wrData[BitAlarmEn];
        hzEn    <= wrData[BitHzEn];
        pairEn  <= wrData[BitPairEn];
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BitAlarmFlag] = alarmFlag;
    statusWord[BitHzFlag]    = hzFlag;
    statusWord[BitAlarmEn]   = alarmEn;
    statusWord[BitHzEn]      = hzEn;
    statusWord[BitPairFlag]  = pairFlag;
    statusWord[BitPairEn]    = pairEn;
  end

  always_comb begin
    rdData = '0;
    if (selStatus) rdData = statusWord;
    if (selDiv)    rdData = divTrimR;
    if (selTime)   rdData = timeWord;
    if (selDate)   rdData = dateWord;
    if (selAlT)    rdData = alarmTime;
    if (selAlD)    rdData = alarmDate;
  end

  assign irq = (alarmFlag & alarmEn) | (hzFlag & hzEn) | (pairFlag & pairEn);

  // R7: the once-per-second flag only rises after a second tick
  a_r7_hz_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hzFlag) |-> $past(secTick));

  // R9: writing 1 clears the alarm flag when no match arrives
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && wrData[BitAlarmFlag] && !timeHit) |=> !alarmFlag);

  // R9: without a write-1 the alarm flag holds
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(wrStatus && wrData[BitAlarmFlag])) |=> alarmFlag);

  // R10: an enabled pair flag keeps irq high
  a_r10_pair_irq: assert property (@(posedge clk) disable iff (!rstN)
    (pairFlag && pairEn) |-> irq);

  // R8: a pair match is always accompanied by a time match
  a_r8_pair_implies_time: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pairFlag) |-> alarmFlag);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int AddrW     = 8,
  parameter int DivW      = 16,
  parameter int YearW     = 12,
  parameter int ResetYear = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick32k,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [RegW-1:0]  wrData,
  output logic [RegW-1:0]  rdData,
  output logic             irq
);
  calStrobeT       strobe;
  logic [DivW-1:0] divCount;
  logic [RegW-1:0] alarmTime, alarmDate, timeWord, dateWord;
  logic            secTick, timeHit, pairHit;

  rtc_cal_ctrl #(.AddrW(AddrW), .DivW(DivW)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .secTick(secTick), .timeHit(timeHit), .pairHit(pairHit),
    .timeWord(timeWord), .dateWord(dateWord), .strobe(strobe),
    .divCount(divCount), .alarmTime(alarmTime), .alarmDate(alarmDate),
    .rdData(rdData), .irq(irq)
  );

  rtc_cal_datapath #(.DivW(DivW), .YearW(YearW), .ResetYear(ResetYear)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick32k), .strobe(strobe), .wrData(wrData),
    .divCount(divCount), .alarmTime(alarmTime), .alarmDate(alarmDate),
    .secTick(secTick), .timeHit(timeHit), .pairHit(pairHit),
    .timeWord(timeWord), .dateWord(dateWord)
  );
endmodule

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick32k = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar_core dut_i (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // behavioural reference model
  int mSec, mMin, mHour, mDay, mMon, mYear, mDivCnt;
  logic [31:0] mDiv, mAlT, mAlD;
  bit mFA, mFH, mFP, mEA, mEH, mEP;

  function automatic logic [31:0] mkTime(int h, int m, int s);
    return (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  function automatic logic [31:0] mkDate(int y, int m, int d);
    return (32'(y) << 9) | (32'(m) << 5) | 32'(d);
  endfunction

  function automatic int daysIn(int m, int y);
    bit leap;
    leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] mStatus();
    return {26'd0, mEP, mFP, mEH, mEA, mFH, mFA};
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    case (a)
      8'h08: return mStatus();
      8'h0C: return mDiv;
      8'h10: return mkTime(mHour, mMin, mSec);
      8'h14: return mkDate(mYear, mMon, mDay);
      8'h18: return mAlT;
      8'h1C: return mAlD;
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelStep();
    int lim;
    bit ldT, ldD, st, tHit, pHit, wS;
    if (!rstN) begin
      mSec = 0; mMin = 0; mHour = 0; mDay = 1; mMon = 1; mYear = 2000;
      mDivCnt = 0; mDiv = 0; mAlT = 0; mAlD = 0;
      mFA = 0; mFH = 0; mFP = 0; mEA = 0; mEH = 0; mEP = 0;
      return;
    end
    lim = (mDiv[15:0] == 0) ? 32767 : int'(mDiv[15:0]);
    ldT = wrEn && addr == 8'h10;
    ldD = wrEn && addr == 8'h14;
    wS  = wrEn && addr == 8'h08;
    st  = tick32k && (mDivCnt >= lim) && !ldT && !ldD;
    if (ldT || ldD) mDivCnt = 0;
    else if (tick32k) mDivCnt = (mDivCnt >= lim) ? 0 : mDivCnt + 1;
    if (ldT) begin
      mSec = int'(wrData[5:0]); mMin = int'(wrData[11:6]); mHour = int'(wrData[16:12]);
    end
    if (ldD) begin
      mDay = int'(wrData[4:0]); mMon = int'(wrData[8:5]); mYear = int'(wrData[20:9]);
    end
    if (st) begin
      mSec++;
      if (mSec == 60) begin
        mSec = 0; mMin++;
        if (mMin == 60) begin
          mMin = 0; mHour++;
          if (mHour == 24) begin
            mHour = 0; mDay++;
            if (mDay > daysIn(mMon, mYear)) begin
              mDay = 1; mMon++;
              if (mMon == 13) begin mMon = 1; mYear = (mYear + 1) % 4096; end
            end
          end
        end
      end
    end
    tHit = st && (mkTime(mHour, mMin, mSec) == mAlT);
    pHit = tHit && (mkDate(mYear, mMon, mDay) == mAlD);
    if (wS) begin
      if (wrData[0]) mFA = 0;
      if (wrData[1]) mFH = 0;
      if (wrData[4]) mFP = 0;
      mEA = wrData[2]; mEH = wrData[3]; mEP = wrData[5];
    end
    if (tHit) mFA = 1;
    if (st)   mFH = 1;
    if (pHit) mFP = 1;
    if (wrEn && addr == 8'h0C) mDiv = wrData;
    if (wrEn && addr == 8'h18) mAlT = wrData & 32'h0001_FFFF;
    if (wrEn && addr == 8'h1C) mAlD = wrData & 32'h001F_FFFF;
  endtask

  function automatic string reqOf(logic [7:0] a);
    case (a)
      8'h08: return "R9";
      8'h0C: return "R2";
      8'h10: return "R5";
      8'h14: return "R6";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    modelStep();
    #1;
    if (rstN && !done) begin
      checks++;
      if (rdData !== mRead(addr)) begin
        errors++;
        $display("FAIL %s model read addr %h: actual %h expected %h", reqOf(addr), addr, rdData, mRead(addr));
      end
      checks++;
      if (irq !== (mFA & mEA | mFH & mEH | mFP & mEP)) begin
        errors++;
        $display("FAIL R10 model irq: actual %b expected %b", irq, (mFA & mEA | mFH & mEH | mFP & mEP));
      end
    end
  end

  task automatic expectRead(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic expectIrq(logic exp, string req);
    @(negedge clk);
    #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick32k = 1'b1;
      @(negedge clk); tick32k = 1'b0;
    end
  endtask

  task automatic tickRun(int n);
    @(negedge clk); tick32k = 1'b1;
    repeat (n) @(negedge clk);
    tick32k = 1'b0;
  endtask

  task automatic rollDay(int y, int m, int d, int ey, int em, int ed, string req);
    busWrite(8'h10, mkTime(23, 59, 59));
    busWrite(8'h14, mkDate(y, m, d));
    ticks(4);
    expectRead(8'h14, mkDate(ey, em, ed), req);
    expectRead(8'h10, mkTime(0, 0, 0), "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectRead(8'h08, 32'h0, "R1");
    expectRead(8'h0C, 32'h0, "R1");
    expectRead(8'h10, 32'h0, "R1");
    expectRead(8'h14, mkDate(2000, 1, 1), "R1");
    expectRead(8'h18, 32'h0, "R1");
    expectRead(8'h1C, 32'h0, "R1");
    expectIrq(1'b0, "R1");

    // R2 divider with trim readback
    busWrite(8'h0C, 32'hABCD_0003);
    expectRead(8'h0C, 32'hABCD_0003, "R2");

    // R5 and R6 year-end rollover
    busWrite(8'h10, mkTime(23, 59, 58));
    busWrite(8'h14, mkDate(2023, 12, 31));
    ticks(4);
    expectRead(8'h10, mkTime(23, 59, 59), "R5");
    ticks(3);
    expectRead(8'h10, mkTime(23, 59, 59), "R2");
    ticks(1);
    expectRead(8'h10, mkTime(0, 0, 0), "R5");
    expectRead(8'h14, mkDate(2024, 1, 1), "R6");

    // R6 month lengths and leap rule
    rollDay(2024, 2, 28, 2024, 2, 29, "R6");
    rollDay(2024, 2, 29, 2024, 3, 1, "R6");
    rollDay(2100, 2, 28, 2100, 3, 1, "R6");
    rollDay(2000, 2, 28, 2000, 2, 29, "R6");
    rollDay(2023, 4, 30, 2023, 5, 1, "R6");

    // R4 write restarts the divider
    ticks(2);
    busWrite(8'h10, mkTime(10, 20, 30));
    ticks(3);
    expectRead(8'h10, mkTime(10, 20, 30), "R4");
    ticks(1);
    expectRead(8'h10, mkTime(10, 20, 31), "R4");

    // R8 pair alarm, R9 write-one-to-clear, R10 irq
    busWrite(8'h18, mkTime(10, 20, 32));
    busWrite(8'h1C, mkDate(2023, 5, 1));
    busWrite(8'h08, 32'h37);
    expectRead(8'h08, 32'h24, "R9");
    expectIrq(1'b0, "R10");
    ticks(4);
    expectRead(8'h08, 32'h37, "R8");
    expectIrq(1'b1, "R10");
    busWrite(8'h08, 32'h24);
    expectRead(8'h08, 32'h37, "R9");
    busWrite(8'h08, 32'h25);
    expectRead(8'h08, 32'h36, "R9");
    expectIrq(1'b1, "R10");
    busWrite(8'h08, 32'h34);
    expectRead(8'h08, 32'h26, "R9");
    expectIrq(1'b0, "R10");
    busWrite(8'h08, 32'h08);
    expectRead(8'h08, 32'h0A, "R9");
    expectIrq(1'b1, "R10");
    busWrite(8'h08, 32'h0A);
    expectRead(8'h08, 32'h08, "R9");
    expectIrq(1'b0, "R10");

    // R8 time match on another date sets bit 0 only
    busWrite(8'h14, mkDate(2023, 5, 2));
    busWrite(8'h10, mkTime(10, 20, 31));
    busWrite(8'h08, 32'h37);
    ticks(4);
    expectRead(8'h08, 32'h27, "R8");
    expectIrq(1'b1, "R10");

    // R3 unmapped offsets
    busWrite(8'h20, 32'hFFFF_FFFF);
    expectRead(8'h20, 32'h0, "R3");
    expectRead(8'h00, 32'h0, "R3");
    expectRead(8'h08, 32'h27, "R3");
    expectRead(8'h0C, 32'hABCD_0003, "R3");

    // R2 zero count behaves as 32767
    busWrite(8'h0C, 32'h0);
    expectRead(8'h0C, 32'h0, "R2");
    busWrite(8'h10, mkTime(1, 2, 3));
    tickRun(32767);
    expectRead(8'h10, mkTime(1, 2, 3), "R2");
    tickRun(1);
    expectRead(8'h10, mkTime(1, 2, 4), "R2");

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule